// File: doc/BRIEF.md
# Dual-Group Conversion Result Registers

This block keeps the latest result of each of the two conversion groups of a multi-channel filter converter: a background (regular) group and a high-priority (injected) group. The filter core signals each finished conversion with a one-cycle strobe. The strobe carries the signed 24-bit value and the 3-bit number of the channel that produced it. For the regular group it also carries a flag that says the result was held back by an injected trigger. The block stores these fields in one 32-bit result word per group.

Software or a DMA engine reads these words over a simple 32-bit register bus. A word read or an upper half-word read of a group's result word clears that group's end-of-conversion flag. When DMA is enabled for a group, the flag is also driven out as a DMA request. If a new result lands while the previous one is still unread, it overwrites the stored word and raises a sticky overrun bit. Only a write to the status word clears that bit.

Top module: `cres_top`

## Requirements
- R1: Word index 0 selects the injected result word and index 1 selects the regular result word. In each, bits 31:8 hold the 24-bit result and bits 2:0 hold the channel number. A read issued in one cycle presents its data on `bus_rdata` in the next cycle, and that data holds until the next read.
- R2: A completion strobe updates the result and channel fields of its group together. The stored channel is the one carried by that strobe, even when the channel differs from the previous conversion's.
- R3: Bit 4 of the regular word is 1 exactly when the latest regular completion arrived with `reg_late` high. Each regular completion rewrites this bit.
- R4: A completion sets its group's end-of-conversion flag. A read of that group's result word clears the flag in the next cycle. Reads of the other group's word or of the status word leave the flag unchanged.
- R5: A read with `bus_half` high returns bits 31:16 of the selected word in `bus_rdata[15:0]`, with zeros in bits 31:16. It clears the group flag exactly as a word read does.
- R6: Bits 7:3 of the injected word read as zero. Bits 7:5 and bit 3 of the regular word read as zero.
- R7: After reset, both result words, `bus_rdata`, every flag, every overrun bit and every DMA request are zero.
- R8: If a read of a group's word and a completion of that group fall in the same cycle, the read returns the old word. The new result is stored, the flag stays set, and no overrun is raised.
- R9: A group's DMA request is high exactly while its DMA enable and its end-of-conversion flag are both high, so a read by the DMA engine drops the request.
- R10: A completion that finds its group flag set, with no read of that group in the same cycle, sets the group's overrun bit and overwrites the stored word. A write to word index 2 clears the injected overrun bit with `bus_wdata[2]` = 1 and the regular overrun bit with `bus_wdata[3]` = 1. A 0 in either position leaves that bit alone.
- R11: Word index 2 reads as the status word: bit 0 is the injected flag, bit 1 the regular flag, bit 2 the injected overrun bit and bit 3 the regular overrun bit. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_done | input | 1 | Injected conversion finished (one cycle) |
| inj_data | input | 24 | Injected result value |
| inj_chan | input | 3 | Channel that produced the injected result |
| reg_done | input | 1 | Regular conversion finished (one cycle) |
| reg_data | input | 24 | Regular result value |
| reg_chan | input | 3 | Channel that produced the regular result |
| reg_late | input | 1 | Regular result was delayed by an injected trigger |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index: 0 injected, 1 regular, 2 status |
| bus_half | input | 1 | Read only the upper half-word |
| bus_wdata | input | 4 | Write data for the status word |
| bus_rdata | output | 32 | Registered read data |
| dma_en_inj | input | 1 | DMA mode for the injected group |
| dma_en_reg | input | 1 | DMA mode for the regular group |
| inj_eoc | output | 1 | Injected end-of-conversion flag |
| reg_eoc | output | 1 | Regular end-of-conversion flag |
| inj_ovr | output | 1 | Injected overrun bit |
| reg_ovr | output | 1 | Regular overrun bit |
| inj_dma_req | output | 1 | Injected DMA request |
| reg_dma_req | output | 1 | Regular DMA request |

## Verification
Two functions of the block can fall in the same cycle: a group's read-clear and the completion strobe of the same group. The bench provokes this by raising `bus_rd` for the regular word in the very cycle that `reg_done` carries a fresh result. It then judges three things. The returned word must be the old result. The flag must still be set with no overrun. A follow-up read must return the new result. The read-clear path also meets a fresh completion over a set flag, which the overrun test covers together with the selective clear of the overrun bits.

// File: rtl/cres_pkg.sv
package cres_pkg;

    localparam int DATA_W   = 24;
    localparam int CH_W     = 3;
    localparam int BUS_W    = 32;
    localparam int HALF_W   = BUS_W / 2;
    localparam int STAT_W   = 4;
    localparam int DATA_LSB = BUS_W - DATA_W;
    localparam int LATE_BIT = 4;

    localparam int ST_INJ_EOC = 0;
    localparam int ST_REG_EOC = 1;
    localparam int ST_INJ_OVR = 2;
    localparam int ST_REG_OVR = 3;

    typedef enum logic [1:0] {
        WIX_INJ  = 2'd0,
        WIX_REG  = 2'd1,
        WIX_STAT = 2'd2,
        WIX_NONE = 2'd3
    } wix_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [CH_W-1:0]   chan;
        logic              late;
    } result_t;

    function automatic logic [BUS_W-1:0] pack_result(input result_t r);
        logic [BUS_W-1:0] w;
        w = '0;
        w[BUS_W-1:DATA_LSB] = r.value;
        w[CH_W-1:0]         = r.chan;
        w[LATE_BIT]         = r.late;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] upper_half(input logic [BUS_W-1:0] w);
        return {{HALF_W{1'b0}}, w[BUS_W-1:HALF_W]};
    endfunction

endpackage

// File: rtl/cres_slot.sv
module cres_slot
    import cres_pkg::*;
#(
    parameter bit KEEP_LATE = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    done,
    input  result_t din,
    input  logic    rd_hit,
    input  logic    ovr_clr,
    input  logic    dma_en,
    output result_t held,
    output logic    eoc,
    output logic    ovr,
    output logic    dma_req
);

    logic late_in;

    generate
        if (KEEP_LATE) begin : g_late
            assign late_in = din.late;
        end else begin : g_nolate
            assign late_in = din.late & 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            eoc  <= 1'b0;
        end else if (done) begin
            held.value <= din.value;
            held.chan  <= din.chan;
            held.late  <= late_in;
            eoc        <= 1'b1;
        end else if (rd_hit) begin
            eoc <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= 1'b0;
        end else if (done && eoc && !rd_hit) begin
            ovr <= 1'b1;
        end else if (ovr_clr) begin
            ovr <= 1'b0;
        end
    end

    assign dma_req = dma_en & eoc;

endmodule

// File: rtl/cres_readport.sv
module cres_readport
    import cres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic              bus_half,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic [BUS_W-1:0]  word_inj,
    input  logic [BUS_W-1:0]  word_reg,
    input  logic [STAT_W-1:0] status,
    output logic              rd_inj,
    output logic              rd_reg,
    output logic              clr_inj,
    output logic              clr_reg,
    output logic [BUS_W-1:0]  bus_rdata
);

    wix_e             wix;
    logic [BUS_W-1:0] sel_word;

    assign wix     = wix_e'(bus_addr);
    assign rd_inj  = bus_rd && (wix == WIX_INJ);
    assign rd_reg  = bus_rd && (wix == WIX_REG);
    assign clr_inj = bus_wr && (wix == WIX_STAT) && bus_wdata[ST_INJ_OVR];
    assign clr_reg = bus_wr && (wix == WIX_STAT) && bus_wdata[ST_REG_OVR];

    always_comb begin
        unique case (wix)
            WIX_INJ:  sel_word = word_inj;
            WIX_REG:  sel_word = word_reg;
            WIX_STAT: sel_word = {{(BUS_W-STAT_W){1'b0}}, status};
            default:  sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= bus_half ? upper_half(sel_word) : sel_word;
        end
    end

endmodule

// File: rtl/cres_top.sv
module cres_top
    import cres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inj_done,
    input  logic [DATA_W-1:0] inj_data,
    input  logic [CH_W-1:0]   inj_chan,
    input  logic              reg_done,
    input  logic [DATA_W-1:0] reg_data,
    input  logic [CH_W-1:0]   reg_chan,
    input  logic              reg_late,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic              bus_half,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dma_en_inj,
    input  logic              dma_en_reg,
    output logic              inj_eoc,
    output logic              reg_eoc,
    output logic              inj_ovr,
    output logic              reg_ovr,
    output logic              inj_dma_req,
    output logic              reg_dma_req
);

    result_t             inj_in, reg_in, inj_held, reg_held;
    logic                rd_inj, rd_reg, clr_inj, clr_reg;
    logic [STAT_W-1:0]   status;

    assign inj_in = '{value: inj_data, chan: inj_chan, late: 1'b0};
    assign reg_in = '{value: reg_data, chan: reg_chan, late: reg_late};

    cres_slot #(.KEEP_LATE(1'b0)) u_inj (
        .clk(clk), .rst(rst), .done(inj_done), .din(inj_in),
        .rd_hit(rd_inj), .ovr_clr(clr_inj), .dma_en(dma_en_inj),
        .held(inj_held), .eoc(inj_eoc), .ovr(inj_ovr), .dma_req(inj_dma_req)
    );

    cres_slot #(.KEEP_LATE(1'b1)) u_reg (
        .clk(clk), .rst(rst), .done(reg_done), .din(reg_in),
        .rd_hit(rd_reg), .ovr_clr(clr_reg), .dma_en(dma_en_reg),
        .held(reg_held), .eoc(reg_eoc), .ovr(reg_ovr), .dma_req(reg_dma_req)
    );

    always_comb begin
        status             = '0;
        status[ST_INJ_EOC] = inj_eoc;
        status[ST_REG_EOC] = reg_eoc;
        status[ST_INJ_OVR] = inj_ovr;
        status[ST_REG_OVR] = reg_ovr;
    end

    cres_readport u_port (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_half(bus_half), .bus_wdata(bus_wdata),
        .word_inj(pack_result(inj_held)), .word_reg(pack_result(reg_held)),
        .status(status), .rd_inj(rd_inj), .rd_reg(rd_reg),
        .clr_inj(clr_inj), .clr_reg(clr_reg), .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/cres_checker.sv
module cres_checker (
    input logic        clk,
    input logic        rst,
    input logic        inj_done,
    input logic        reg_done,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic        bus_half,
    input logic [31:0] bus_rdata,
    input logic        inj_eoc,
    input logic        reg_eoc,
    input logic        inj_ovr,
    input logic        reg_ovr,
    input logic        inj_dma_req,
    input logic        reg_dma_req
);

    AST_EOC_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        inj_done |=> inj_eoc); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0 && !inj_done) |=> !inj_eoc); // R4

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && reg_done) |=> (reg_eoc && $stable(reg_ovr))); // R8

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_half) |=> (bus_rdata[31:16] == 16'h0)); // R5

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_half && bus_addr == 2'd1) |=> (bus_rdata[7:5] == 3'b0 && !bus_rdata[3])); // R6

    AST_DMA_INJ: assert property (@(posedge clk) disable iff (rst)
        inj_dma_req |-> inj_eoc); // R9

    AST_DMA_REG: assert property (@(posedge clk) disable iff (rst)
        reg_dma_req |-> reg_eoc); // R9

    AST_OVR_REG: assert property (@(posedge clk) disable iff (rst)
        (reg_done && reg_eoc && !(bus_rd && bus_addr == 2'd1)) |=> reg_ovr); // R10

    AST_OVR_INJ: assert property (@(posedge clk) disable iff (rst)
        (inj_done && inj_eoc && !(bus_rd && bus_addr == 2'd0)) |=> inj_ovr); // R10

endmodule

bind cres_top cres_checker u_chk (
    .clk(clk), .rst(rst), .inj_done(inj_done), .reg_done(reg_done),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_half(bus_half),
    .bus_rdata(bus_rdata), .inj_eoc(inj_eoc), .reg_eoc(reg_eoc),
    .inj_ovr(inj_ovr), .reg_ovr(reg_ovr),
    .inj_dma_req(inj_dma_req), .reg_dma_req(reg_dma_req)
);

// File: tb/cres_top_bench.sv
module cres_top_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 6;
    // {group(1=regular), late, chan[2:0], value[23:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 3'd5, 24'h800001},
        {1'b1, 1'b1, 3'd3, 24'h7FFFFF},
        {1'b1, 1'b0, 3'd6, 24'h123456},
        {1'b0, 1'b0, 3'd0, 24'hFFFFFF},
        {1'b1, 1'b1, 3'd7, 24'h000100},
        {1'b0, 1'b0, 3'd2, 24'h00A5C3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inj_done = 0, reg_done = 0, reg_late = 0;
    logic [23:0] inj_data = '0, reg_data = '0;
    logic [2:0]  inj_chan = '0, reg_chan = '0;
    logic        bus_rd = 0, bus_wr = 0, bus_half = 0;
    logic [1:0]  bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dma_en_inj = 0, dma_en_reg = 0;
    logic        inj_eoc, reg_eoc, inj_ovr, reg_ovr, inj_dma_req, reg_dma_req;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cres_top u_cres_top (
        .clk(clk), .rst(rst),
        .inj_done(inj_done), .inj_data(inj_data), .inj_chan(inj_chan),
        .reg_done(reg_done), .reg_data(reg_data), .reg_chan(reg_chan),
        .reg_late(reg_late), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_half(bus_half), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dma_en_inj(dma_en_inj), .dma_en_reg(dma_en_reg),
        .inj_eoc(inj_eoc), .reg_eoc(reg_eoc), .inj_ovr(inj_ovr),
        .reg_ovr(reg_ovr), .inj_dma_req(inj_dma_req), .reg_dma_req(reg_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic grp, input logic late,
                                            input logic [2:0] ch, input logic [23:0] v);
        return {v, 3'b0, grp & late, 1'b0, ch};
    endfunction

    // inputs change right after a falling edge; results are sampled at the next one
    task automatic conv(input logic grp, input logic late, input logic [2:0] ch,
                        input logic [23:0] v);
        if (grp) begin
            reg_done = 1; reg_data = v; reg_chan = ch; reg_late = late;
        end else begin
            inj_done = 1; inj_data = v; inj_chan = ch;
        end
        @(negedge clk);
        inj_done = 0; reg_done = 0; reg_late = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic half);
        bus_rd = 1; bus_addr = a; bus_half = half;
        @(negedge clk);
        bus_rd = 0; bus_half = 0;
    endtask

    task automatic wr(input logic [3:0] d);
        bus_wr = 1; bus_addr = 2'd2; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R7 reset state
        chk("R7 eoc", {30'b0, reg_eoc, inj_eoc}, 32'h0);
        chk("R7 ovr", {30'b0, reg_ovr, inj_ovr}, 32'h0);
        chk("R7 dma", {30'b0, reg_dma_req, inj_dma_req}, 32'h0);
        rd(2'd0, 1'b0);
        chk("R7 injected word", bus_rdata, 32'h0);
        rd(2'd1, 1'b0);
        chk("R7 regular word", bus_rdata, 32'h0);

        // R1 R2 R3 R4 R6 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic grp;
            grp = VEC[i][28];
            conv(grp, VEC[i][27], VEC[i][26:24], VEC[i][23:0]);
            chk("R4 flag set", {31'b0, grp ? reg_eoc : inj_eoc}, 32'h1);
            rd({1'b0, grp}, 1'b0);
            chk("R1 R2 R3 R6 packed word", bus_rdata,
                word_of(grp, VEC[i][27], VEC[i][26:24], VEC[i][23:0]));
            chk("R4 flag cleared", {31'b0, grp ? reg_eoc : inj_eoc}, 32'h0);
        end

        // R5 half-word read
        conv(1'b1, 1'b0, 3'd1, 24'hABCDEF);
        rd(2'd1, 1'b1);
        chk("R5 half data", bus_rdata, 32'h0000ABCD);
        chk("R5 half clears", {31'b0, reg_eoc}, 32'h0);

        // R4 R11 other reads leave the flag alone
        conv(1'b0, 1'b0, 3'd4, 24'h111111);
        rd(2'd1, 1'b0);
        chk("R4 other group read", {31'b0, inj_eoc}, 32'h1);
        rd(2'd2, 1'b0);
        chk("R11 status word", bus_rdata, 32'h1);
        chk("R4 status read", {31'b0, inj_eoc}, 32'h1);
        rd(2'd0, 1'b0);
        chk("R4 own read", {31'b0, inj_eoc}, 32'h0);

        // R2 R10 overrun with new channel tag, selective clear
        conv(1'b1, 1'b0, 3'd2, 24'h0A0A0A);
        conv(1'b1, 1'b0, 3'd6, 24'h0B0B0B);
        chk("R10 overrun set", {31'b0, reg_ovr}, 32'h1);
        rd(2'd2, 1'b0);
        chk("R11 status overrun", bus_rdata, 32'hA);
        rd(2'd1, 1'b0);
        chk("R2 R10 overwritten tag", bus_rdata, word_of(1'b1, 1'b0, 3'd6, 24'h0B0B0B));
        wr(4'b0100);
        chk("R10 other bit no effect", {31'b0, reg_ovr}, 32'h1);
        wr(4'b1000);
        chk("R10 cleared", {31'b0, reg_ovr}, 32'h0);

        // R8 collision of read and completion
        conv(1'b1, 1'b0, 3'd1, 24'h0C0C0C);
        bus_rd = 1; bus_addr = 2'd1;
        reg_done = 1; reg_data = 24'h0D0D0D; reg_chan = 3'd2; reg_late = 1;
        @(negedge clk);
        bus_rd = 0; reg_done = 0; reg_late = 0;
        chk("R8 old word returned", bus_rdata, word_of(1'b1, 1'b0, 3'd1, 24'h0C0C0C));
        chk("R8 flag kept", {31'b0, reg_eoc}, 32'h1);
        chk("R8 no overrun", {31'b0, reg_ovr}, 32'h0);
        rd(2'd1, 1'b0);
        chk("R8 new word stored", bus_rdata, word_of(1'b1, 1'b1, 3'd2, 24'h0D0D0D));

        // R9 DMA request
        dma_en_inj = 1;
        @(negedge clk);
        chk("R9 idle", {31'b0, inj_dma_req}, 32'h0);
        conv(1'b0, 1'b0, 3'd3, 24'h202020);
        chk("R9 raised", {31'b0, inj_dma_req}, 32'h1);
        chk("R9 other group off", {31'b0, reg_dma_req}, 32'h0);
        rd(2'd0, 1'b0);
        chk("R9 dropped by read", {31'b0, inj_dma_req}, 32'h0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule